// File: doc/BRIEF.md
# SMBus Host Block Data Buffer

This block is the payload store that an SMBus host controller uses for block transfers. It holds up to 32 bytes, which is the largest block the protocol permits. Software sees it through a small register window. A single data port walks through the buffer, and every access to the port steps a software index forward by one. A length register holds the byte count. A debug register reports the software index and two sticky overflow flags. The buffer is live only while an enable bit in the auxiliary register is set. Software sets this bit before a block transaction, reads it back to confirm buffer mode, and clears it once the transaction is over.

The software index returns to zero whenever the host control register is read. That register lives outside this block, so its read strobe arrives on a dedicated input. The bus protocol engine has its own side: a separate pointer with start, push and pop strobes, a byte read path, and a load path for the count that a slave returns. The two sides never share an index. Software can fill the buffer for a write while the engine drains it, and the reverse holds for a read.

Register offsets on the software window: 0 is the length, 1 is the data port, 2 is the auxiliary control, 3 is the debug register. Any other offset reads as zero.

Top module: `sbuf_block`

## Requirements
- R1: After reset the enable bit is clear, the software and engine indices are zero, both overflow flags are clear, the length is zero and every buffer entry is zero.
- R2: A software write to offset 2 loads bit 1 of the write data into the enable bit. A read of offset 2 returns the enable bit in bit 1 and zero in every other bit. The enable bit also drives `buf_en_o`.
- R3: With the enable bit set, each write to offset 1 stores the byte at the entry the software index selects and advances the index. Each read of offset 1 returns that entry and advances the index. Consecutive accesses therefore cover consecutive entries.
- R4: A pulse on `hctl_rd_i` sets the software index to zero on the next edge. A port access in the same cycle is ignored entirely.
- R5: With the enable bit clear, port accesses and engine push or pop leave the buffer and both indices unchanged, and a read of offset 1 returns zero.
- R6: Each index counts up to 32 and stops there. An access made while the index is 32 targets entry 31 and sets a sticky overflow flag (software flag at debug bit 0, engine flag at debug bit 1). Writing 1 to that bit of offset 3 clears the flag. A new overflow in the same cycle takes priority over the clear.
- R7: The engine pointer is cleared by `eng_start_i` and advanced by `eng_push_i` (store `eng_wdata_i`) or `eng_pop_i`. `eng_rdata_o` always shows the entry at the engine pointer. A start pulse wins over a push or pop in the same cycle. Software port accesses never move the engine pointer, and engine strobes never move the software index.
- R8: Offset 0 reads and writes the length register, and `eng_len_o` presents it. `eng_len_we_i` loads `eng_len_i` into it. If the engine and software load it in the same cycle, the engine value is kept.
- R9: `len_err_o` is high exactly when the length is 0 or greater than 32.
- R10: If the engine and software write the same entry in the same cycle, the engine byte is kept.
- R11: Debug offset 3 reads the software index (0 to 32) in bits 7:2, the engine overflow flag in bit 1 and the software overflow flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_addr_i | input | 3 | Software register offset |
| sw_wr_i | input | 1 | Software write strobe |
| sw_rd_i | input | 1 | Software read strobe (side effects only) |
| sw_wdata_i | input | 8 | Software write data |
| sw_rdata_o | output | 8 | Software read data for the offset on `sw_addr_i` |
| hctl_rd_i | input | 1 | Host control register read seen; clears the software index |
| eng_start_i | input | 1 | Engine pointer clear |
| eng_push_i | input | 1 | Engine byte store and step |
| eng_pop_i | input | 1 | Engine byte consume and step |
| eng_wdata_i | input | 8 | Engine byte to store |
| eng_rdata_o | output | 8 | Entry at the engine pointer |
| eng_len_we_i | input | 1 | Engine load of the length register |
| eng_len_i | input | 8 | Count received from the slave |
| eng_len_o | output | 8 | Current length register |
| len_err_o | output | 1 | Length is 0 or above 32 |
| buf_en_o | output | 1 | Buffer mode enabled |

## Verification
Several rules are checked by properties on every cycle: the effect of an enable write, the index clear after a host control read, the single step per enabled port access, index stability while disabled or idle, engine pointer stability without strobes, the stickiness of the software overflow, and the length load and error flag after an engine load. Other rules depend on a history of many cycles, and only the bench scenarios can show them. These are the byte order across a full fill and drain, what entry 31 holds after saturation, who wins when both sides write the same entry, and the zero data returned while disabled. The bench reaches them by comparing every output with its behavioural model on each clock.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFS_LEN  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_PORT = 3'd1;
  localparam logic [REG_AW-1:0] OFS_AUX  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_DBG  = 3'd3;
  localparam int AUX_EN_BIT  = 1;
  localparam int DBG_SOVF_BIT = 0;
  localparam int DBG_EOVF_BIT = 1;
endpackage

// File: rtl/sbuf_index.sv
module sbuf_index #(
  parameter int DEPTH  = 32,
  parameter int IDX_W  = $clog2(DEPTH + 1),
  parameter int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              ovf_clr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              ovf_o
);
  localparam logic [IDX_W-1:0]  LAST      = IDX_W'(DEPTH);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = step_i && !clr_i && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (clr_i)                        idx_q <= '0;
      else if (step_i && idx_q != LAST) idx_q <= idx_q + 1'b1;
      if (wrap)           ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  // saturated index addresses the last entry
  assign slot_o = (idx_q == LAST) ? LAST_SLOT : idx_q[SLOT_W-1:0];
  assign idx_o  = idx_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/sbuf_store.sv
module sbuf_store #(
  parameter int DEPTH  = 32,
  parameter int DW     = 8,
  parameter int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [SLOT_W-1:0] sw_slot_i,
  input  logic [DW-1:0]     sw_wdata_i,
  output logic [DW-1:0]     sw_rdata_o,
  input  logic              eng_we_i,
  input  logic [SLOT_W-1:0] eng_slot_i,
  input  logic [DW-1:0]     eng_wdata_i,
  output logic [DW-1:0]     eng_rdata_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] hit_sw, hit_eng;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign hit_sw[i]  = sw_we_i  && (sw_slot_i  == SLOT_W'(i));
    assign hit_eng[i] = eng_we_i && (eng_slot_i == SLOT_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hit_eng[i])     mem_q[i] <= eng_wdata_i;  // engine wins a collision
        else if (hit_sw[i]) mem_q[i] <= sw_wdata_i;
      end
    end
  end

  assign sw_rdata_o  = mem_q[sw_slot_i];
  assign eng_rdata_o = mem_q[eng_slot_i];
endmodule

// File: rtl/sbuf_block.sv
module sbuf_block
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] sw_addr_i,
  input  logic              sw_wr_i,
  input  logic              sw_rd_i,
  input  logic [DW-1:0]     sw_wdata_i,
  output logic [DW-1:0]     sw_rdata_o,
  input  logic              hctl_rd_i,
  input  logic              eng_start_i,
  input  logic              eng_push_i,
  input  logic              eng_pop_i,
  input  logic [DW-1:0]     eng_wdata_i,
  output logic [DW-1:0]     eng_rdata_o,
  input  logic              eng_len_we_i,
  input  logic [DW-1:0]     eng_len_i,
  output logic [DW-1:0]     eng_len_o,
  output logic              len_err_o,
  output logic              buf_en_o
);
  localparam int IDX_W  = $clog2(DEPTH + 1);
  localparam int SLOT_W = $clog2(DEPTH);
  localparam logic [DW-1:0] MAX_LEN = DW'(DEPTH);

  logic              en_q;
  logic [DW-1:0]     len_q;
  logic              sw_acc, sw_we, eng_acc, eng_we, dbg_wr;
  logic [IDX_W-1:0]  sw_idx, eng_idx;
  logic [SLOT_W-1:0] sw_slot, eng_slot;
  logic              sw_ovf, eng_ovf;
  logic [DW-1:0]     port_rdata;

  assign sw_acc  = en_q && (sw_addr_i == OFS_PORT) && (sw_wr_i || sw_rd_i) && !hctl_rd_i;
  assign sw_we   = sw_acc && sw_wr_i;
  assign eng_acc = en_q && (eng_push_i || eng_pop_i) && !eng_start_i;
  assign eng_we  = en_q && eng_push_i && !eng_start_i;
  assign dbg_wr  = sw_wr_i && (sw_addr_i == OFS_DBG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      len_q <= '0;
    end else begin
      if (sw_wr_i && sw_addr_i == OFS_AUX) en_q <= sw_wdata_i[AUX_EN_BIT];
      if (eng_len_we_i)                         len_q <= eng_len_i;
      else if (sw_wr_i && sw_addr_i == OFS_LEN) len_q <= sw_wdata_i;
    end
  end

  sbuf_index #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) i_sw_index (
    .clk_i, .rst_ni,
    .clr_i     (hctl_rd_i),
    .step_i    (sw_acc),
    .ovf_clr_i (dbg_wr && sw_wdata_i[DBG_SOVF_BIT]),
    .idx_o     (sw_idx),
    .slot_o    (sw_slot),
    .ovf_o     (sw_ovf)
  );

  sbuf_index #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) i_eng_index (
    .clk_i, .rst_ni,
    .clr_i     (eng_start_i),
    .step_i    (eng_acc),
    .ovf_clr_i (dbg_wr && sw_wdata_i[DBG_EOVF_BIT]),
    .idx_o     (eng_idx),
    .slot_o    (eng_slot),
    .ovf_o     (eng_ovf)
  );

  sbuf_store #(.DEPTH(DEPTH), .DW(DW), .SLOT_W(SLOT_W)) i_store (
    .clk_i, .rst_ni,
    .sw_we_i     (sw_we),
    .sw_slot_i   (sw_slot),
    .sw_wdata_i  (sw_wdata_i),
    .sw_rdata_o  (port_rdata),
    .eng_we_i    (eng_we),
    .eng_slot_i  (eng_slot),
    .eng_wdata_i (eng_wdata_i),
    .eng_rdata_o (eng_rdata_o)
  );

  always_comb begin
    sw_rdata_o = '0;
    case (sw_addr_i)
      OFS_LEN:  sw_rdata_o = len_q;
      OFS_PORT: sw_rdata_o = en_q ? port_rdata : '0;
      OFS_AUX:  sw_rdata_o[AUX_EN_BIT] = en_q;
      OFS_DBG:  sw_rdata_o = DW'({sw_idx, eng_ovf, sw_ovf});
      default:  sw_rdata_o = '0;
    endcase
  end

  assign eng_len_o = len_q;
  assign len_err_o = (len_q == '0) || (len_q > MAX_LEN);
  assign buf_en_o  = en_q;
endmodule

// File: rtl/sbuf_block_chk.sv
module sbuf_block_chk
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] sw_addr_i,
  input logic              sw_wr_i,
  input logic              sw_rd_i,
  input logic [DW-1:0]     sw_wdata_i,
  input logic              hctl_rd_i,
  input logic              eng_start_i,
  input logic              eng_push_i,
  input logic              eng_pop_i,
  input logic              eng_len_we_i,
  input logic [DW-1:0]     eng_len_i,
  input logic [DW-1:0]     eng_len_o,
  input logic              len_err_o,
  input logic              buf_en_o,
  input logic [IDX_W-1:0]  sw_idx,
  input logic [IDX_W-1:0]  eng_idx,
  input logic              sw_ovf
);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(DEPTH);
  localparam logic [DW-1:0]    MAX_LEN = DW'(DEPTH);

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && sw_addr_i == OFS_AUX) |=> (buf_en_o == $past(sw_wdata_i[AUX_EN_BIT]))); // R2

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_en_o && sw_addr_i == OFS_PORT && (sw_wr_i || sw_rd_i) && !hctl_rd_i && sw_idx != LAST)
    |=> (sw_idx == IDX_W'($past(sw_idx) + 1'b1))); // R3

  AST_IDX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hctl_rd_i |=> (sw_idx == '0)); // R4

  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!buf_en_o && !hctl_rd_i) |=> $stable(sw_idx)); // R5

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_idx <= LAST) && (eng_idx <= LAST)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_ovf && !(sw_wr_i && sw_addr_i == OFS_DBG && sw_wdata_i[DBG_SOVF_BIT])) |=> sw_ovf); // R6

  AST_ENG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eng_start_i || eng_push_i || eng_pop_i) |=> $stable(eng_idx)); // R7

  AST_LEN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_len_we_i |=> (eng_len_o == $past(eng_len_i))); // R8

  AST_LEN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_len_we_i && (eng_len_i == '0 || eng_len_i > MAX_LEN)) |=> len_err_o); // R9
endmodule

bind sbuf_block sbuf_block_chk #(.DEPTH(DEPTH), .DW(DW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sw_addr_i    (sw_addr_i),
  .sw_wr_i      (sw_wr_i),
  .sw_rd_i      (sw_rd_i),
  .sw_wdata_i   (sw_wdata_i),
  .hctl_rd_i    (hctl_rd_i),
  .eng_start_i  (eng_start_i),
  .eng_push_i   (eng_push_i),
  .eng_pop_i    (eng_pop_i),
  .eng_len_we_i (eng_len_we_i),
  .eng_len_i    (eng_len_i),
  .eng_len_o    (eng_len_o),
  .len_err_o    (len_err_o),
  .buf_en_o     (buf_en_o),
  .sw_idx       (sw_idx),
  .eng_idx      (eng_idx),
  .sw_ovf       (sw_ovf)
);

// File: tb/test_sbuf_block.sv
`timescale 1ns/1ps
module test_sbuf_block;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sw_addr = '0;
  logic       sw_wr = 1'b0, sw_rd = 1'b0, hctl_rd = 1'b0;
  logic [7:0] sw_wdata = '0;
  logic       eng_start = 1'b0, eng_push = 1'b0, eng_pop = 1'b0, eng_len_we = 1'b0;
  logic [7:0] eng_wdata = '0, eng_len = '0;
  logic [7:0] sw_rdata, eng_rdata, eng_len_out;
  logic       len_err, buf_en;

  int n_cmp = 0, n_bad = 0;

  // behavioural model
  int m_mem[32];
  int m_sidx = 0, m_eidx = 0, m_len = 0;
  bit m_en = 0, m_sovf = 0, m_eovf = 0;

  always #2 clk = ~clk;

  sbuf_block i_sbuf_block (
    .clk_i(clk), .rst_ni(rst_n),
    .sw_addr_i(sw_addr), .sw_wr_i(sw_wr), .sw_rd_i(sw_rd), .sw_wdata_i(sw_wdata),
    .sw_rdata_o(sw_rdata), .hctl_rd_i(hctl_rd),
    .eng_start_i(eng_start), .eng_push_i(eng_push), .eng_pop_i(eng_pop),
    .eng_wdata_i(eng_wdata), .eng_rdata_o(eng_rdata),
    .eng_len_we_i(eng_len_we), .eng_len_i(eng_len), .eng_len_o(eng_len_out),
    .len_err_o(len_err), .buf_en_o(buf_en)
  );

  function automatic int slot(input int idx);
    return (idx >= 32) ? 31 : idx;
  endfunction

  function automatic logic [7:0] exp_sw();
    case (sw_addr)
      3'd0: return 8'(m_len);
      3'd1: return m_en ? 8'(m_mem[slot(m_sidx)]) : 8'h00;
      3'd2: return {6'b0, m_en, 1'b0};
      3'd3: return {6'(m_sidx), m_eovf, m_sovf};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int n_sidx = m_sidx, n_eidx = m_eidx;
    bit swacc, eacc;
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_sidx = 0; m_eidx = 0; m_len = 0; m_en = 0; m_sovf = 0; m_eovf = 0;
      return;
    end
    swacc = m_en && sw_addr == 3'd1 && (sw_wr || sw_rd) && !hctl_rd;
    eacc  = m_en && (eng_push || eng_pop) && !eng_start;
    if (swacc && sw_wr) m_mem[slot(m_sidx)] = sw_wdata;
    if (eacc && eng_push) m_mem[slot(m_eidx)] = eng_wdata;
    if (hctl_rd) n_sidx = 0; else if (swacc && m_sidx < 32) n_sidx++;
    if (eng_start) n_eidx = 0; else if (eacc && m_eidx < 32) n_eidx++;
    if (swacc && m_sidx == 32) m_sovf = 1;
    else if (sw_wr && sw_addr == 3'd3 && sw_wdata[0]) m_sovf = 0;
    if (eacc && m_eidx == 32) m_eovf = 1;
    else if (sw_wr && sw_addr == 3'd3 && sw_wdata[1]) m_eovf = 0;
    if (sw_wr && sw_addr == 3'd2) m_en = sw_wdata[1];
    if (eng_len_we) m_len = eng_len;
    else if (sw_wr && sw_addr == 3'd0) m_len = sw_wdata;
    m_sidx = n_sidx; m_eidx = n_eidx;
  endtask

  // inputs are held from the previous negedge; compare, clock, update model
  task automatic cyc(input string req);
    #1;
    check(req, "sw_rdata", sw_rdata, exp_sw());
    check(req, "eng_rdata", eng_rdata, 8'(m_mem[slot(m_eidx)]));
    check(req, "len_err", {7'b0, len_err}, {7'b0, (m_len == 0 || m_len > 32)});
    check(req, "eng_len", eng_len_out, 8'(m_len));
    check(req, "buf_en", {7'b0, buf_en}, {7'b0, m_en});
    @(posedge clk);
    model_step();
    @(negedge clk);
    sw_wr = 0; sw_rd = 0; hctl_rd = 0; eng_start = 0; eng_push = 0; eng_pop = 0; eng_len_we = 0;
  endtask

  task automatic sw_write(input logic [2:0] a, input logic [7:0] d, input string req);
    sw_addr = a; sw_wdata = d; sw_wr = 1; cyc(req);
  endtask

  task automatic sw_read(input logic [2:0] a, input string req);
    sw_addr = a; sw_rd = 1; cyc(req);
  endtask

  task automatic peek(input logic [2:0] a, input string req);
    sw_addr = a; cyc(req);
  endtask

  task automatic hctl(input string req);
    hctl_rd = 1; cyc(req);
  endtask

  initial begin
    foreach (m_mem[i]) m_mem[i] = 0;
    @(negedge clk);
    // R1: reset state
    peek(3'd0, "R1"); peek(3'd2, "R1"); peek(3'd3, "R1");
    rst_n = 1;
    peek(3'd3, "R1"); peek(3'd1, "R1");

    // R5: disabled port and engine accesses have no effect
    sw_write(3'd1, 8'hA5, "R5");
    sw_read(3'd1, "R5");
    eng_push = 1; eng_wdata = 8'h3C; cyc("R5");
    peek(3'd3, "R5");

    // R2: enable write and readback
    sw_write(3'd2, 8'hFF, "R2");
    peek(3'd2, "R2");
    peek(3'd1, "R5");

    // R3/R4: fill and drain in order
    hctl("R4");
    for (int i = 0; i < 5; i++) sw_write(3'd1, 8'(8'h10 + i), "R3");
    peek(3'd3, "R11");
    hctl_rd = 1; sw_addr = 3'd1; sw_wr = 1; sw_wdata = 8'hEE; cyc("R4");
    peek(3'd3, "R4");
    for (int i = 0; i < 5; i++) sw_read(3'd1, "R3");

    // R6: saturation and sticky overflow
    hctl("R4");
    for (int i = 0; i < 34; i++) sw_write(3'd1, 8'(8'h40 + i), "R6");
    peek(3'd3, "R6");
    sw_read(3'd1, "R6");
    sw_write(3'd3, 8'h01, "R6");
    peek(3'd3, "R11");

    // R7: engine pointer independent of software index
    eng_start = 1; eng_push = 1; eng_wdata = 8'h99; cyc("R7");
    for (int i = 0; i < 3; i++) begin eng_push = 1; eng_wdata = 8'(8'hC0 + i); cyc("R7"); end
    peek(3'd3, "R7");
    eng_start = 1; cyc("R7");
    for (int i = 0; i < 3; i++) begin eng_pop = 1; cyc("R7"); end
    hctl("R7");
    for (int i = 0; i < 3; i++) sw_read(3'd1, "R7");
    eng_start = 1; cyc("R7");
    for (int i = 0; i < 34; i++) begin eng_pop = 1; cyc("R6"); end
    peek(3'd3, "R6");
    sw_write(3'd3, 8'h02, "R6");
    peek(3'd3, "R11");

    // R8/R9: length register and its error flag
    sw_write(3'd0, 8'd0, "R9");
    sw_write(3'd0, 8'd32, "R9");
    sw_write(3'd0, 8'd33, "R9");
    sw_write(3'd0, 8'd1, "R9");
    eng_len_we = 1; eng_len = 8'd5; sw_addr = 3'd0; sw_wr = 1; sw_wdata = 8'd9; cyc("R8");
    peek(3'd0, "R8");
    eng_len_we = 1; eng_len = 8'd0; cyc("R9");
    peek(3'd0, "R9");

    // R10: same-entry collision
    hctl_rd = 1; eng_start = 1; cyc("R10");
    sw_addr = 3'd1; sw_wr = 1; sw_wdata = 8'h11; eng_push = 1; eng_wdata = 8'h22; cyc("R10");
    hctl("R10");
    sw_read(3'd1, "R10");

    // R5: disable again; reads return zero and nothing moves
    sw_write(3'd2, 8'h00, "R5");
    hctl("R5");
    sw_read(3'd1, "R5");
    sw_write(3'd1, 8'h77, "R5");
    eng_pop = 1; cyc("R5");
    peek(3'd3, "R5");
    sw_write(3'd2, 8'h02, "R2");
    sw_read(3'd1, "R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule